// File: doc/BRIEF.md
# Direct-Mapped Data Cache Tag Tracker

This block watches a processor data bus and models a direct-mapped L1 data cache without holding any data. For each access that falls inside a configured cacheable window it looks up the row picked by the address index, compares the stored tag, and reports a hit on a one-cycle pulse. Misses allocate according to the write policy chosen at build time. Every row's resident block start address can be read back through a plain register port. This lets software running on the prototype inspect what the cache would contain at any moment.

The bus side uses valid/ready. `bus_ready` is high while the tracker is idle and can classify a new access. An access is taken when `bus_valid` and `bus_ready` are both high on a rising edge. The tracker only observes the bus and can never stall it, so `bus_ready` is advisory: an access presented while `bus_ready` is low is not tracked at all. A taken access holds `bus_ready` low for one cycle on a hit. It holds it low for two cycles when the line is allocated.

A 32-bit control/status word enables or disables tracking and flushes all rows. Line length (4 or 8 words), row count (2^`IDX_BITS`), window base and window size, and write policy are parameters.

Top module: `shadow_cache_tracker`

## Requirements
- R1: After reset every row is invalid and reads back 0, `hit` is low, `bus_ready` is high, and the control word reads 1 (tracking enabled).
- R2: `bus_rnw`=1 marks a read and `bus_rnw`=0 marks a write. A read miss allocates its row. The row then reads back the address with the low log2(4*LINE_WORDS) bits cleared, so 0x90005400, 0x9000540C and 0x90005408 with 4-word lines all show 0x90005400.
- R3: With WRITE_THROUGH=1, a write hit or miss never allocates. With 4-word lines, 16 rows and base 0x90004000, the sequence read 0x90005400, write 0x9000540C, write 0x90005410, read 0x90005408, read 0x90005420, write 0x90005434 gives miss, hit, miss, hit, miss, miss.
- R4: With WRITE_THROUGH=0, a write miss allocates its row, and a later read of the same block hits.
- R5: `hit` rises in the cycle after the access is taken, lasts exactly one cycle, and `bus_ready` is low in that cycle.
- R6: Addresses whose bits above MEM_ADDR_BITS differ from BASE_ADDR are ignored: no hit, `bus_ready` stays high, no row changes.
- R7: Control bit 0 is the enable. While it is 0, accesses produce no hit, leave `bus_ready` high and change no row. Writing it back to 1 resumes tracking.
- R8: Writing control bit 1 as 1 invalidates all rows on that edge. The bit reads back as 0.
- R9: `reg_sel` with its top bit set reads the control word `{31'b0, enable}`. Otherwise the top bit is clear and the low IDX_BITS bits pick a row, which reads its block address when valid and 0 when invalid.
- R10: A read miss on a valid row with a different tag replaces that row's block.
- R11: With 8-word lines (32-byte blocks), all accesses inside one 32-byte block share a row. The sequence from R3, with write-back and 8 rows, gives miss, hit, hit, hit, miss, hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus address phase valid |
| bus_ready | output | 1 | Tracker idle and able to classify an access |
| bus_addr | input | 32 | Byte address on the bus |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| hit | output | 1 | One-cycle hit pulse |
| csr_we | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data (bit 0 enable, bit 1 flush) |
| reg_sel | input | IDX_BITS+1 | Register select: top bit picks control word, else row index |
| reg_rdata | output | 32 | Selected register contents |

## Verification
Two instances run side by side on the same stimulus. One uses write-through with 4-word lines and 16 rows. The other uses write-back with 8-word lines and 8 rows. The R3 sequence therefore separates the policies and the line lengths in one pass. A write then a read to one block tells write allocation apart from none. Two blocks that map to the same row show replacement. Accesses just outside the window, accesses while disabled, and a flush show that the rows are left alone when they should be, and the row readback confirms it.

// File: rtl/scache_pkg.sv
package scache_pkg;
  typedef enum logic [1:0] {
    ST_CHECK  = 2'd0,
    ST_READ   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_UPDATE = 2'd3
  } trk_state_e;

  localparam int CSR_EN_BIT    = 0;
  localparam int CSR_FLUSH_BIT = 1;
endpackage

// File: rtl/scache_addr_split.sv
module scache_addr_split #(
  parameter logic [31:0] BASE_ADDR     = 32'h9000_4000,
  parameter int          MEM_ADDR_BITS = 14,
  parameter int          OFF_BITS      = 4,
  parameter int          IDX_BITS      = 4,
  parameter int          TAG_W         = 6
) (
  input  logic [31:0]         addr,
  output logic                in_range,
  output logic [IDX_BITS-1:0] idx,
  output logic [TAG_W-1:0]    tag
);
  always_comb begin
    in_range = (addr[31:MEM_ADDR_BITS] == BASE_ADDR[31:MEM_ADDR_BITS]);
    idx      = addr[OFF_BITS +: IDX_BITS];
    tag      = addr[OFF_BITS+IDX_BITS +: TAG_W];
  end
endmodule

// File: rtl/scache_tag_array.sv
module scache_tag_array #(
  parameter int IDX_BITS = 4,
  parameter int TAG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [IDX_BITS-1:0] lk_idx,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic                lk_hit,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag
);
  localparam int ROWS = 1 << IDX_BITS;

  logic [ROWS-1:0]  row_valid;
  logic [TAG_W-1:0] row_tag [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_valid[r] <= 1'b0;
        row_tag[r]   <= '0;
      end else if (flush) begin
        row_valid[r] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_BITS'(r))) begin
        row_valid[r] <= 1'b1;
        row_tag[r]   <= wr_tag;
      end
    end
  end

  always_comb begin
    lk_hit   = row_valid[lk_idx] && (row_tag[lk_idx] == lk_tag);
    rd_valid = row_valid[rd_idx];
    rd_tag   = row_tag[rd_idx];
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(row_valid) == 0)); // R8

  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> row_valid[$past(wr_idx)]); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($countones(row_valid) <= $countones($past(row_valid)))); // R6
endmodule

// File: rtl/scache_ctrl.sv
module scache_ctrl
  import scache_pkg::*;
#(
  parameter bit WRITE_THROUGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic acc_rd,
  input  logic lk_hit,
  output logic ready,
  output logic hit,
  output logic tag_wr
);
  trk_state_e state_q, state_d;
  trk_state_e wr_miss_next;

  if (WRITE_THROUGH) begin : g_wt
    assign wr_miss_next = ST_CHECK;
  end else begin : g_wb
    assign wr_miss_next = ST_UPDATE;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CHECK:  if (accept) state_d = acc_rd ? ST_READ : ST_WRITE;
      ST_READ:   state_d = lk_hit ? ST_CHECK : ST_UPDATE;
      ST_WRITE:  state_d = lk_hit ? ST_CHECK : wr_miss_next;
      ST_UPDATE: state_d = ST_CHECK;
      default:   state_d = ST_CHECK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_CHECK;
    else        state_q <= state_d;
  end

  always_comb begin
    ready  = (state_q == ST_CHECK);
    hit    = ((state_q == ST_READ) || (state_q == ST_WRITE)) && lk_hit;
    tag_wr = (state_q == ST_UPDATE);
  end

  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit); // R5

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ready) |=> !ready); // R5

  AST_READ_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && !lk_hit) |=> tag_wr); // R2

  if (WRITE_THROUGH) begin : g_chk_wt
    AST_WT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE) |=> ready); // R3
  end else begin : g_chk_wb
    AST_WB_WRITE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE && !lk_hit) |=> tag_wr); // R4
  end
endmodule

// File: rtl/shadow_cache_tracker.sv
module shadow_cache_tracker
  import scache_pkg::*;
#(
  parameter int          LINE_WORDS    = 4,
  parameter int          IDX_BITS      = 4,
  parameter bit          WRITE_THROUGH = 1'b1,
  parameter logic [31:0] BASE_ADDR     = 32'h9000_4000,
  parameter int          MEM_ADDR_BITS = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic [31:0]         bus_addr,
  input  logic                bus_rnw,
  output logic                hit,
  input  logic                csr_we,
  input  logic [31:0]         csr_wdata,
  input  logic [IDX_BITS:0]   reg_sel,
  output logic [31:0]         reg_rdata
);
  localparam int          OFF_BITS = 2 + $clog2(LINE_WORDS);
  localparam int          TAG_W    = MEM_ADDR_BITS - OFF_BITS - IDX_BITS;
  localparam int          TAG_LSB  = OFF_BITS + IDX_BITS;
  localparam logic [31:0] BASE_HI  = BASE_ADDR & ~((32'd1 << MEM_ADDR_BITS) - 32'd1);

  logic                en_q;
  logic                flush;
  logic                accept;
  logic [31:0]         lat_addr;
  logic                bus_in_range, lat_in_range;
  logic [IDX_BITS-1:0] bus_idx, lat_idx, rd_idx;
  logic [TAG_W-1:0]    bus_tag, lat_tag, rd_tag;
  logic                lk_hit, rd_valid, tag_wr;
  logic [31:0]         rd_block;

  // control word
  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= 1'b1;
    else if (csr_we) en_q <= csr_wdata[CSR_EN_BIT];
  end
  assign flush = csr_we && csr_wdata[CSR_FLUSH_BIT];

  scache_addr_split #(
    .BASE_ADDR(BASE_ADDR), .MEM_ADDR_BITS(MEM_ADDR_BITS),
    .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS), .TAG_W(TAG_W)
  ) u_bus_split (
    .addr(bus_addr), .in_range(bus_in_range), .idx(bus_idx), .tag(bus_tag)
  );

  scache_addr_split #(
    .BASE_ADDR(BASE_ADDR), .MEM_ADDR_BITS(MEM_ADDR_BITS),
    .OFF_BITS(OFF_BITS), .IDX_BITS(IDX_BITS), .TAG_W(TAG_W)
  ) u_lat_split (
    .addr(lat_addr), .in_range(lat_in_range), .idx(lat_idx), .tag(lat_tag)
  );

  assign accept = bus_valid && bus_ready && en_q && bus_in_range;

  always_ff @(posedge clk) begin
    if (!rst_n)      lat_addr <= '0;
    else if (accept) lat_addr <= bus_addr;
  end

  scache_ctrl #(.WRITE_THROUGH(WRITE_THROUGH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .acc_rd(bus_rnw),
    .lk_hit(lk_hit), .ready(bus_ready), .hit(hit), .tag_wr(tag_wr)
  );

  scache_tag_array #(.IDX_BITS(IDX_BITS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(tag_wr), .wr_idx(lat_idx), .wr_tag(lat_tag),
    .lk_idx(lat_idx), .lk_tag(lat_tag), .lk_hit(lk_hit),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_tag(rd_tag)
  );

  // register readback
  assign rd_idx = reg_sel[IDX_BITS-1:0];
  always_comb begin
    rd_block = BASE_HI | (32'(rd_tag) << TAG_LSB) | (32'(rd_idx) << OFF_BITS);
    if (reg_sel[IDX_BITS])  reg_rdata = {31'd0, en_q};
    else if (rd_valid)      reg_rdata = rd_block;
    else                    reg_rdata = 32'd0;
  end

  AST_LOOKUP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> lat_in_range); // R6

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_in_range) |=> bus_ready); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !en_q) |=> (bus_ready && !hit)); // R7
endmodule

// File: tb/tb_shadow_cache_tracker.sv
module tb_shadow_cache_tracker;
  localparam logic [31:0] BASE = 32'h9000_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rnw = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        rd_csr = 1'b0;
  int          rd_row = 0;
  logic [4:0]  sel_a;
  logic [3:0]  sel_b;
  logic        rdy_a, rdy_b, hit_a, hit_b;
  logic [31:0] rdata_a, rdata_b;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1 reset";
  bit    done     = 1'b0;

  always #10 clk = ~clk;

  assign sel_a = {rd_csr, 4'(rd_row)};
  assign sel_b = {rd_csr, 3'(rd_row)};

  shadow_cache_tracker #(.LINE_WORDS(4), .IDX_BITS(4), .WRITE_THROUGH(1'b1),
    .BASE_ADDR(BASE), .MEM_ADDR_BITS(14)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(rdy_a),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .hit(hit_a), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .reg_sel(sel_a), .reg_rdata(rdata_a));

  shadow_cache_tracker #(.LINE_WORDS(8), .IDX_BITS(3), .WRITE_THROUGH(1'b0),
    .BASE_ADDR(BASE), .MEM_ADDR_BITS(14)) dut_wb (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(rdy_b),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .hit(hit_b), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .reg_sel(sel_b), .reg_rdata(rdata_b));

  // ---------------- behavioural reference model ----------------
  bit          m_val [2][128];
  int unsigned m_blk [2][128];
  int          m_st  [2];
  int unsigned m_adr [2];
  bit          m_rd  [2];
  bit          m_en = 1'b1;
  bit          exp_hit [2];
  bit          exp_rdy [2];

  function automatic int unsigned line_of(int c); return (c == 0) ? 16 : 32; endfunction
  function automatic int          rows_of(int c); return (c == 0) ? 16 : 8;  endfunction
  function automatic bit          wt_of(int c);   return (c == 0);           endfunction
  function automatic int row_of(int c, int unsigned a);
    return int'((a / line_of(c)) % rows_of(c));
  endfunction
  function automatic int unsigned blk_of(int c, int unsigned a);
    return a - (a % line_of(c));
  endfunction
  function automatic bit in_win(int unsigned a);
    return (a >= BASE) && (a < BASE + 32'h4000);
  endfunction
  function automatic bit m_lookup(int c, int unsigned a);
    return m_val[c][row_of(c, a)] && (m_blk[c][row_of(c, a)] == blk_of(c, a));
  endfunction
  function automatic logic [31:0] exp_rdata(int c);
    int r;
    r = rd_row % rows_of(c);
    if (rd_csr) return {31'd0, m_en};
    return m_val[c][r] ? m_blk[c][r] : 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        for (int r = 0; r < 128; r++) m_val[c][r] = 1'b0;
        m_st[c] = 0; exp_hit[c] = 1'b0; exp_rdy[c] = 1'b1;
      end
      m_en = 1'b1;
    end else begin
      for (int c = 0; c < 2; c++) begin
        int nxt;
        nxt = 0;
        case (m_st[c])
          0: if (bus_valid && m_en && in_win(bus_addr)) begin
               m_adr[c] = bus_addr; m_rd[c] = bus_rnw; nxt = 1;
             end
          1: if (m_lookup(c, m_adr[c])) nxt = 0;
             else if (m_rd[c] || !wt_of(c)) nxt = 2;
             else nxt = 0;
          default: begin
            m_val[c][row_of(c, m_adr[c])] = 1'b1;
            m_blk[c][row_of(c, m_adr[c])] = blk_of(c, m_adr[c]);
          end
        endcase
        if (csr_we && csr_wdata[1])
          for (int r = 0; r < 128; r++) m_val[c][r] = 1'b0;
        m_st[c]    = nxt;
        exp_rdy[c] = (nxt == 0);
        exp_hit[c] = (nxt == 1) && m_lookup(c, m_adr[c]);
      end
      if (csr_we) m_en = csr_wdata[0];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({phase, " hit A"},   32'(hit_a), 32'(exp_hit[0]));
      chk({phase, " hit B"},   32'(hit_b), 32'(exp_hit[1]));
      chk({phase, " ready A"}, 32'(rdy_a), 32'(exp_rdy[0]));
      chk({phase, " ready B"}, 32'(rdy_b), 32'(exp_rdy[1]));
      chk({phase, " rdata A"}, rdata_a,    exp_rdata(0));
      chk({phase, " rdata B"}, rdata_b,    exp_rdata(1));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic access(input logic [31:0] a, input bit rd, input bit taken,
                        output bit h_a, output bit h_b);
    @(negedge clk); #1;
    bus_addr = a; bus_rnw = rd; bus_valid = 1'b1;
    @(negedge clk);
    h_a = hit_a; h_b = hit_b;
    chk({phase, " R5 ready during lookup A"}, 32'(rdy_a), 32'(!taken));
    #1 bus_valid = 1'b0;
    @(negedge clk);
    chk({phase, " R5 hit lasts one cycle A"}, 32'(hit_a), 32'd0);
    chk({phase, " R5 hit lasts one cycle B"}, 32'(hit_b), 32'd0);
    while (!(rdy_a && rdy_b)) @(negedge clk);
  endtask

  task automatic csr_write(input logic [31:0] v);
    @(negedge clk); #1;
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic read_reg(input bit is_csr, input int row,
                          output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); #1;
    rd_csr = is_csr; rd_row = row;
    @(negedge clk);
    va = rdata_a; vb = rdata_b;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] addrs [6];
    bit          rds   [6];
    bit          ea    [6];
    bit          eb    [6];
    bit          ha, hb;
    logic [31:0] va, vb;
    addrs = '{32'h9000_5400, 32'h9000_540C, 32'h9000_5410,
              32'h9000_5408, 32'h9000_5420, 32'h9000_5434};
    rds   = '{1, 0, 0, 1, 1, 0};
    ea    = '{0, 1, 0, 1, 0, 0};
    eb    = '{0, 1, 1, 1, 0, 1};

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    phase = "R1 reset";
    chk("R1 ready A", 32'(rdy_a), 32'd1);
    chk("R1 hit A", 32'(hit_a), 32'd0);
    read_reg(1'b0, 5, va, vb);
    chk("R1 row5 empty A", va, 32'd0);
    chk("R1 row5 empty B", vb, 32'd0);
    read_reg(1'b1, 0, va, vb);
    chk("R1 R9 control word", va, 32'd1);

    phase = "R3 R11 sequence";
    for (int i = 0; i < 6; i++) begin
      access(addrs[i], rds[i], 1'b1, ha, hb);
      chk($sformatf("R3 write-through step %0d", i), 32'(ha), 32'(ea[i]));
      chk($sformatf("R11 eight-word step %0d", i), 32'(hb), 32'(eb[i]));
    end
    read_reg(1'b0, 0, va, vb);
    chk("R2 block address A row0", va, 32'h9000_5400);
    chk("R2 block address B row0", vb, 32'h9000_5400);
    read_reg(1'b0, 1, va, vb);
    chk("R3 write miss not filled A row1", va, 32'd0);
    chk("R11 block address B row1", vb, 32'h9000_5420);

    phase = "R4 write allocate";
    access(32'h9000_5460, 1'b0, 1'b1, ha, hb);
    chk("R3 write miss A", 32'(ha), 32'd0);
    chk("R4 write miss B", 32'(hb), 32'd0);
    access(32'h9000_5460, 1'b1, 1'b1, ha, hb);
    chk("R3 no allocation on write A", 32'(ha), 32'd0);
    chk("R4 write-allocated read hits B", 32'(hb), 32'd1);

    phase = "R10 replacement";
    access(32'h9000_5500, 1'b1, 1'b1, ha, hb);
    chk("R10 conflict miss A", 32'(ha), 32'd0);
    read_reg(1'b0, 0, va, vb);
    chk("R10 row0 replaced A", va, 32'h9000_5500);
    chk("R10 row0 replaced B", vb, 32'h9000_5500);
    access(32'h9000_5400, 1'b1, 1'b1, ha, hb);
    chk("R10 evicted block misses A", 32'(ha), 32'd0);
    chk("R10 evicted block misses B", 32'(hb), 32'd0);

    phase = "R6 outside window";
    access(32'h9000_8000, 1'b1, 1'b0, ha, hb);
    chk("R6 above window no hit", 32'(ha | hb), 32'd0);
    access(32'h9000_3FF0, 1'b0, 1'b0, ha, hb);
    chk("R6 below window no hit", 32'(ha | hb), 32'd0);
    read_reg(1'b0, 0, va, vb);
    chk("R6 row0 untouched A", va, 32'h9000_5400);

    phase = "R7 disabled";
    csr_write(32'd0);
    read_reg(1'b1, 0, va, vb);
    chk("R7 R9 control reads disabled", va, 32'd0);
    access(32'h9000_5400, 1'b1, 1'b0, ha, hb);
    chk("R7 resident block gives no hit while disabled", 32'(ha | hb), 32'd0);
    access(32'h9000_5580, 1'b0, 1'b0, ha, hb);
    read_reg(1'b0, 4, va, vb);
    chk("R7 write while disabled leaves row4 B empty", vb, 32'd0);
    csr_write(32'd1);
    access(32'h9000_5400, 1'b1, 1'b1, ha, hb);
    chk("R7 tracking resumes A", 32'(ha), 32'd1);

    phase = "R8 flush";
    csr_write(32'd3);
    read_reg(1'b0, 0, va, vb);
    chk("R8 R9 flushed row reads zero A", va, 32'd0);
    chk("R8 R9 flushed row reads zero B", vb, 32'd0);
    read_reg(1'b1, 0, va, vb);
    chk("R8 flush bit reads back zero", va, 32'd1);
    access(32'h9000_5400, 1'b1, 1'b1, ha, hb);
    chk("R8 miss after flush A", 32'(ha), 32'd0);
    chk("R8 miss after flush B", 32'(hb), 32'd0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end
endmodule